// File: doc/BRIEF.md
# Reorder Buffer with In-Order Commit

This block lets execution units finish instructions in any order while the architectural register file changes strictly in program order. Each decoded instruction claims the next slot of a circular buffer and receives that slot number as its tag. When it finishes executing, its result and an error flag are written into the slot. The oldest slot retires only when it has finished, and retiring writes its result into the register file held inside the block.

Each architectural register has a rename field: a "settled" bit and a tag. A settled register's value comes from the register file. An unsettled register's value comes from the buffer slot named by its tag, so an operand lookup never searches the buffer by register number. A completion that arrives in the same cycle as a lookup is forwarded to that lookup. An error flag is acted on only when its instruction reaches the oldest position. At that point nothing is retired, every in-flight slot is discarded, and one cycle later a redirect to the handler is raised with the faulting PC. An external flush input also discards everything that is in flight.

Control is a two-state machine. `S_RUN` is normal operation. `S_TRAP` is the single cycle in which the redirect is presented. The transition RUN→TRAP happens when the oldest slot has finished with its error flag set. TRAP→RUN is unconditional after one cycle.

Top module: `reorder_buffer`

## Requirements
- R1: An accepted dispatch (`disp_valid` and `disp_ready` both high) allocates the slot shown on `disp_tag`. Successive accepted dispatches receive consecutive tags modulo DEPTH (DEPTH is a power of two).
- R2: `disp_ready` is low while DEPTH instructions are in flight, during the `S_TRAP` cycle, and in any cycle where a flush or trap is being taken. A dispatch offered while `disp_ready` is low allocates nothing.
- R3: A completion writes its result and error flag into its own slot only. The register file is unchanged until that slot retires.
- R4: Only the oldest slot retires, and only once it has completed without error, at most one per cycle. `retire_valid` then shows its write flag, destination, result and PC, and the register file takes the result on that edge.
- R5: A lookup of a register with no pending writer returns the register-file value with `src_ready` high.
- R6: A lookup of a register with a pending writer takes the value from the slot named by its rename tag once that slot has completed. Until then `src_ready` is low and `src_tag` carries the tag of the youngest writer.
- R7: A completion presented in the same cycle as a lookup of its tag is forwarded to that lookup, with `src_ready` high and the completion data.
- R8: At retire, the destination's rename field returns to settled only if its tag still names the retiring slot. A younger writer keeps the register pointing at its own slot.
- R9: When the oldest slot has completed with its error flag set, it does not retire, all slots are discarded, and all registers become settled. In the next cycle `exc_valid` is high for exactly one cycle with `exc_pc` equal to that slot's PC.
- R10: `flush_req` discards all slots and settles all registers, and nothing retires in that cycle. The next allocated tag continues from the oldest position. A trap taken in the same cycle takes precedence and still raises `exc_valid`.
- R11: After reset no slot is in flight, `disp_ready` is high, and every register reads as settled with value zero.
- R12: A completion carrying the tag of a slot that is not in flight is ignored. A slot allocated later at that tag starts as not completed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_valid | input | 1 | Instruction offered for allocation |
| disp_we | input | 1 | Instruction writes a destination register |
| disp_dst | input | REG_W | Destination register number |
| disp_pc | input | PC_W | Instruction PC |
| disp_ready | output | 1 | A slot can be allocated this cycle |
| disp_tag | output | TAG_W | Slot that an accepted dispatch takes |
| cmp_valid | input | 1 | Completion writeback |
| cmp_tag | input | TAG_W | Slot being completed |
| cmp_data | input | DATA_W | Result value |
| cmp_exc | input | 1 | Instruction raised an error |
| src_reg | input | NUM_SRC*REG_W | Registers looked up, one field per source |
| src_ready | output | NUM_SRC | Operand value is available |
| src_data | output | NUM_SRC*DATA_W | Operand values |
| src_tag | output | NUM_SRC*TAG_W | Producer slot of each operand |
| retire_valid | output | 1 | Oldest slot retires this cycle |
| retire_we | output | 1 | Retiring instruction writes a register |
| retire_dst | output | REG_W | Register written at retire |
| retire_data | output | DATA_W | Value written at retire |
| retire_pc | output | PC_W | PC of the retiring instruction |
| flush_req | input | 1 | Discard all in-flight slots |
| exc_valid | output | 1 | Redirect to handler (S_TRAP) |
| exc_pc | output | PC_W | PC of the faulting instruction |

## Verification
The bench builds the block with DEPTH=4, NUM_REGS=8, DATA_W=16, PC_W=16 and NUM_SRC=2. A four-slot buffer fills after four dispatches and its pointers wrap every few retirements, so full-stall, tag reuse after a flush and wrap-around happen many times in a short run. Eight registers make it likely that a destination is renamed twice while both writers are still in flight. That puts the conditional rename release and the youngest-writer lookup within reach of both the directed sequences and the long pseudo-random stretch.

// File: rtl/rob_pkg.sv
package rob_pkg;

    typedef enum logic [0:0] {
        S_RUN  = 1'b0,
        S_TRAP = 1'b1
    } rob_state_e;

endpackage

// File: rtl/rob_ctrl.sv
module rob_ctrl
    import rob_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int PC_W  = 32,
    localparam int TAG_W = $clog2(DEPTH),
    localparam int PTR_W = TAG_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             disp_valid,
    input  logic             flush_req,
    input  logic             head_done,
    input  logic             head_exc,
    input  logic [PC_W-1:0]  head_pc,
    output logic             disp_ready,
    output logic             disp_fire,
    output logic             retire_fire,
    output logic             trap_enter,
    output logic             flush_all,
    output logic [TAG_W-1:0] head_idx,
    output logic [TAG_W-1:0] tail_idx,
    output logic             exc_valid,
    output logic [PC_W-1:0]  exc_pc
);

    rob_state_e       state_q, state_d;
    logic [PTR_W-1:0] head_q, tail_q, used;
    logic             is_full, is_empty, head_ready;
    logic [PC_W-1:0]  exc_pc_q;

    assign used       = tail_q - head_q;
    assign is_full    = (used == PTR_W'(DEPTH));
    assign is_empty   = (used == '0);
    assign head_ready = !is_empty && head_done && (state_q == S_RUN);

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_RUN:  if (head_ready && head_exc) state_d = S_TRAP;
            S_TRAP: state_d = S_RUN;
            default: state_d = S_RUN;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_RUN;
        else        state_q <= state_d;
    end

    // Outputs of the state machine
    always_comb begin
        trap_enter  = 1'b0;
        retire_fire = 1'b0;
        exc_valid   = 1'b0;
        unique case (state_q)
            S_RUN: begin
                trap_enter  = head_ready && head_exc;
                retire_fire = head_ready && !head_exc && !flush_req;
            end
            S_TRAP: exc_valid = 1'b1;
            default: ;
        endcase
        flush_all  = trap_enter || flush_req;
        disp_ready = (state_q == S_RUN) && !is_full && !flush_all;
        disp_fire  = disp_valid && disp_ready;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q   <= '0;
            tail_q   <= '0;
            exc_pc_q <= '0;
        end else begin
            if (trap_enter) exc_pc_q <= head_pc;
            if (flush_all) begin
                tail_q <= head_q;
            end else begin
                if (retire_fire) head_q <= head_q + PTR_W'(1);
                if (disp_fire)   tail_q <= tail_q + PTR_W'(1);
            end
        end
    end

    assign head_idx = head_q[TAG_W-1:0];
    assign tail_idx = tail_q[TAG_W-1:0];
    assign exc_pc   = exc_pc_q;

endmodule

// File: rtl/rob_storage.sv
module rob_storage #(
    parameter int DEPTH    = 16,
    parameter int NUM_REGS = 32,
    parameter int DATA_W   = 32,
    parameter int PC_W     = 32,
    localparam int TAG_W = $clog2(DEPTH),
    localparam int REG_W = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_all,
    input  logic              alloc_en,
    input  logic [TAG_W-1:0]  alloc_idx,
    input  logic              alloc_we,
    input  logic [REG_W-1:0]  alloc_dst,
    input  logic [PC_W-1:0]   alloc_pc,
    input  logic              cmp_en,
    input  logic [TAG_W-1:0]  cmp_idx,
    input  logic [DATA_W-1:0] cmp_data,
    input  logic              cmp_exc,
    input  logic              pop_en,
    input  logic [TAG_W-1:0]  rd_idx,
    output logic              rd_done,
    output logic              rd_exc,
    output logic              rd_we,
    output logic [REG_W-1:0]  rd_dst,
    output logic [DATA_W-1:0] rd_data,
    output logic [PC_W-1:0]   rd_pc,
    output logic [DEPTH-1:0]  done_vec,
    output logic [DATA_W-1:0] res_arr [DEPTH]
);

    logic [DEPTH-1:0]  valid_q, done_q, exc_q, we_q;
    logic [REG_W-1:0]  dst_q [DEPTH];
    logic [PC_W-1:0]   pc_q  [DEPTH];
    logic [DATA_W-1:0] res_q [DEPTH];

    always_ff @(posedge clk) begin
        for (int e = 0; e < DEPTH; e++) begin
            if (!rst_n || clear_all) begin
                valid_q[e] <= 1'b0;
                done_q[e]  <= 1'b0;
                exc_q[e]   <= 1'b0;
            end else if (alloc_en && alloc_idx == TAG_W'(e)) begin
                valid_q[e] <= 1'b1;
                done_q[e]  <= 1'b0;
                exc_q[e]   <= 1'b0;
            end else if (pop_en && rd_idx == TAG_W'(e)) begin
                valid_q[e] <= 1'b0;
                done_q[e]  <= 1'b0;
            end else if (cmp_en && cmp_idx == TAG_W'(e) && valid_q[e]) begin
                done_q[e]  <= 1'b1;
                exc_q[e]   <= cmp_exc;
            end
        end
    end

    // Payload fields carry no reset; validity lives in valid_q/done_q
    always_ff @(posedge clk) begin
        for (int e = 0; e < DEPTH; e++) begin
            if (alloc_en && alloc_idx == TAG_W'(e)) begin
                we_q[e]  <= alloc_we;
                dst_q[e] <= alloc_dst;
                pc_q[e]  <= alloc_pc;
            end
            if (cmp_en && cmp_idx == TAG_W'(e) && valid_q[e] && !clear_all)
                res_q[e] <= cmp_data;
        end
    end

    assign rd_done  = done_q[rd_idx];
    assign rd_exc   = exc_q[rd_idx];
    assign rd_we    = we_q[rd_idx];
    assign rd_dst   = dst_q[rd_idx];
    assign rd_data  = res_q[rd_idx];
    assign rd_pc    = pc_q[rd_idx];
    assign done_vec = done_q;
    assign res_arr  = res_q;

endmodule

// File: rtl/rob_regmap.sv
module rob_regmap #(
    parameter int NUM_REGS = 32,
    parameter int DATA_W   = 32,
    parameter int DEPTH    = 16,
    localparam int TAG_W = $clog2(DEPTH),
    localparam int REG_W = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_all,
    input  logic              alloc_en,
    input  logic              alloc_we,
    input  logic [REG_W-1:0]  alloc_dst,
    input  logic [TAG_W-1:0]  alloc_tag,
    input  logic              ret_en,
    input  logic              ret_we,
    input  logic [REG_W-1:0]  ret_dst,
    input  logic [DATA_W-1:0] ret_data,
    input  logic [TAG_W-1:0]  ret_tag,
    output logic [NUM_REGS-1:0] settled,
    output logic [TAG_W-1:0]  ren_tag [NUM_REGS],
    output logic [DATA_W-1:0] arf     [NUM_REGS]
);

    logic [NUM_REGS-1:0] settled_q;
    logic [TAG_W-1:0]    tag_q  [NUM_REGS];
    logic [DATA_W-1:0]   arf_q  [NUM_REGS];

    always_ff @(posedge clk) begin
        for (int r = 0; r < NUM_REGS; r++) begin
            if (!rst_n) begin
                settled_q[r] <= 1'b1;
                tag_q[r]     <= '0;
                arf_q[r]     <= '0;
            end else begin
                if (ret_en && ret_we && ret_dst == REG_W'(r))
                    arf_q[r] <= ret_data;
                if (clear_all) begin
                    settled_q[r] <= 1'b1;
                end else if (alloc_en && alloc_we && alloc_dst == REG_W'(r)) begin
                    settled_q[r] <= 1'b0;
                    tag_q[r]     <= alloc_tag;
                end else if (ret_en && ret_we && ret_dst == REG_W'(r)
                             && !settled_q[r] && tag_q[r] == ret_tag) begin
                    settled_q[r] <= 1'b1;
                end
            end
        end
    end

    assign settled = settled_q;
    assign ren_tag = tag_q;
    assign arf     = arf_q;

endmodule

// File: rtl/rob_operand_mux.sv
module rob_operand_mux #(
    parameter int NUM_REGS = 32,
    parameter int DATA_W   = 32,
    parameter int DEPTH    = 16,
    localparam int TAG_W = $clog2(DEPTH),
    localparam int REG_W = $clog2(NUM_REGS)
) (
    input  logic [REG_W-1:0]    reg_idx,
    input  logic [NUM_REGS-1:0] settled,
    input  logic [TAG_W-1:0]    ren_tag [NUM_REGS],
    input  logic [DATA_W-1:0]   arf     [NUM_REGS],
    input  logic [DEPTH-1:0]    done_vec,
    input  logic [DATA_W-1:0]   res_arr [DEPTH],
    input  logic                cmp_en,
    input  logic [TAG_W-1:0]    cmp_idx,
    input  logic [DATA_W-1:0]   cmp_data,
    output logic                ready,
    output logic [DATA_W-1:0]   value,
    output logic [TAG_W-1:0]    tag
);

    always_comb begin
        tag   = ren_tag[reg_idx];
        ready = 1'b1;
        value = '0;
        if (settled[reg_idx])                value = arf[reg_idx];
        else if (done_vec[tag])              value = res_arr[tag];
        else if (cmp_en && cmp_idx == tag)   value = cmp_data;
        else                                 ready = 1'b0;
    end

endmodule

// File: rtl/reorder_buffer.sv
module reorder_buffer #(
    parameter int DEPTH    = 16,
    parameter int NUM_REGS = 32,
    parameter int DATA_W   = 32,
    parameter int PC_W     = 32,
    parameter int NUM_SRC  = 2,
    localparam int TAG_W = $clog2(DEPTH),
    localparam int REG_W = $clog2(NUM_REGS)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      disp_valid,
    input  logic                      disp_we,
    input  logic [REG_W-1:0]          disp_dst,
    input  logic [PC_W-1:0]           disp_pc,
    output logic                      disp_ready,
    output logic [TAG_W-1:0]          disp_tag,
    input  logic                      cmp_valid,
    input  logic [TAG_W-1:0]          cmp_tag,
    input  logic [DATA_W-1:0]         cmp_data,
    input  logic                      cmp_exc,
    input  logic [NUM_SRC*REG_W-1:0]  src_reg,
    output logic [NUM_SRC-1:0]        src_ready,
    output logic [NUM_SRC*DATA_W-1:0] src_data,
    output logic [NUM_SRC*TAG_W-1:0]  src_tag,
    output logic                      retire_valid,
    output logic                      retire_we,
    output logic [REG_W-1:0]          retire_dst,
    output logic [DATA_W-1:0]         retire_data,
    output logic [PC_W-1:0]           retire_pc,
    input  logic                      flush_req,
    output logic                      exc_valid,
    output logic [PC_W-1:0]           exc_pc
);

    logic              disp_fire, retire_fire, trap_enter, flush_all;
    logic [TAG_W-1:0]  head_idx, tail_idx;
    logic              head_done, head_exc, head_we;
    logic [REG_W-1:0]  head_dst;
    logic [DATA_W-1:0] head_res;
    logic [PC_W-1:0]   head_pc;
    logic [DEPTH-1:0]  done_vec;
    logic [DATA_W-1:0] res_arr [DEPTH];
    logic [NUM_REGS-1:0] settled;
    logic [TAG_W-1:0]  ren_tag [NUM_REGS];
    logic [DATA_W-1:0] arf     [NUM_REGS];

    rob_ctrl #(.DEPTH(DEPTH), .PC_W(PC_W)) ctrl_i (
        .clk(clk), .rst_n(rst_n),
        .disp_valid(disp_valid), .flush_req(flush_req),
        .head_done(head_done), .head_exc(head_exc), .head_pc(head_pc),
        .disp_ready(disp_ready), .disp_fire(disp_fire),
        .retire_fire(retire_fire), .trap_enter(trap_enter), .flush_all(flush_all),
        .head_idx(head_idx), .tail_idx(tail_idx),
        .exc_valid(exc_valid), .exc_pc(exc_pc)
    );

    rob_storage #(.DEPTH(DEPTH), .NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .PC_W(PC_W)) store_i (
        .clk(clk), .rst_n(rst_n), .clear_all(flush_all),
        .alloc_en(disp_fire), .alloc_idx(tail_idx), .alloc_we(disp_we),
        .alloc_dst(disp_dst), .alloc_pc(disp_pc),
        .cmp_en(cmp_valid), .cmp_idx(cmp_tag), .cmp_data(cmp_data), .cmp_exc(cmp_exc),
        .pop_en(retire_fire), .rd_idx(head_idx),
        .rd_done(head_done), .rd_exc(head_exc), .rd_we(head_we), .rd_dst(head_dst),
        .rd_data(head_res), .rd_pc(head_pc),
        .done_vec(done_vec), .res_arr(res_arr)
    );

    rob_regmap #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .DEPTH(DEPTH)) map_i (
        .clk(clk), .rst_n(rst_n), .clear_all(flush_all),
        .alloc_en(disp_fire), .alloc_we(disp_we), .alloc_dst(disp_dst), .alloc_tag(tail_idx),
        .ret_en(retire_fire), .ret_we(head_we), .ret_dst(head_dst),
        .ret_data(head_res), .ret_tag(head_idx),
        .settled(settled), .ren_tag(ren_tag), .arf(arf)
    );

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
        rob_operand_mux #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .DEPTH(DEPTH)) mux_i (
            .reg_idx(src_reg[s*REG_W +: REG_W]),
            .settled(settled), .ren_tag(ren_tag), .arf(arf),
            .done_vec(done_vec), .res_arr(res_arr),
            .cmp_en(cmp_valid), .cmp_idx(cmp_tag), .cmp_data(cmp_data),
            .ready(src_ready[s]),
            .value(src_data[s*DATA_W +: DATA_W]),
            .tag(src_tag[s*TAG_W +: TAG_W])
        );
    end

    assign disp_tag     = tail_idx;
    assign retire_valid = retire_fire;
    assign retire_we    = head_we;
    assign retire_dst   = head_dst;
    assign retire_data  = head_res;
    assign retire_pc    = head_pc;

endmodule

// File: rtl/rob_checker.sv
module rob_checker #(
    parameter int TAG_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             disp_valid,
    input logic             disp_ready,
    input logic [TAG_W-1:0] disp_tag,
    input logic             retire_valid,
    input logic [TAG_W-1:0] head_idx,
    input logic             exc_valid,
    input logic             flush_req
);

    p_tag_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_valid && disp_ready) |=> disp_tag == TAG_W'($past(disp_tag) + 1'b1));

    p_head_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        retire_valid |=> head_idx == TAG_W'($past(head_idx) + 1'b1));

    p_trap_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        exc_valid |-> (!retire_valid && !disp_ready));

    p_trap_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        exc_valid |=> !exc_valid);

    p_flush_no_retire_r10: assert property (@(posedge clk) disable iff (!rst_n)
        flush_req |-> !retire_valid);

    p_flush_drains_r10: assert property (@(posedge clk) disable iff (!rst_n)
        flush_req |=> !retire_valid);

endmodule

bind reorder_buffer rob_checker #(.TAG_W(TAG_W)) chk_i (
    .clk(clk), .rst_n(rst_n),
    .disp_valid(disp_valid), .disp_ready(disp_ready), .disp_tag(disp_tag),
    .retire_valid(retire_valid), .head_idx(head_idx),
    .exc_valid(exc_valid), .flush_req(flush_req)
);

// File: tb/reorder_buffer_tb_top.sv
module reorder_buffer_tb_top;

    localparam int D  = 4;
    localparam int NR = 8;
    localparam int DW = 16;
    localparam int PW = 16;
    localparam int NS = 2;
    localparam int TW = 2;
    localparam int AW = 3;

    logic clk = 1'b0;
    logic rst_n;
    logic disp_valid, disp_we;
    logic [AW-1:0] disp_dst;
    logic [PW-1:0] disp_pc;
    logic disp_ready;
    logic [TW-1:0] disp_tag;
    logic cmp_valid, cmp_exc;
    logic [TW-1:0] cmp_tag;
    logic [DW-1:0] cmp_data;
    logic [NS*AW-1:0] src_reg;
    logic [NS-1:0] src_ready;
    logic [NS*DW-1:0] src_data;
    logic [NS*TW-1:0] src_tag;
    logic retire_valid, retire_we;
    logic [AW-1:0] retire_dst;
    logic [DW-1:0] retire_data;
    logic [PW-1:0] retire_pc;
    logic flush_req, exc_valid;
    logic [PW-1:0] exc_pc;

    always #4 clk = ~clk;

    reorder_buffer #(.DEPTH(D), .NUM_REGS(NR), .DATA_W(DW), .PC_W(PW), .NUM_SRC(NS)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .disp_valid(disp_valid), .disp_we(disp_we), .disp_dst(disp_dst), .disp_pc(disp_pc),
        .disp_ready(disp_ready), .disp_tag(disp_tag),
        .cmp_valid(cmp_valid), .cmp_tag(cmp_tag), .cmp_data(cmp_data), .cmp_exc(cmp_exc),
        .src_reg(src_reg), .src_ready(src_ready), .src_data(src_data), .src_tag(src_tag),
        .retire_valid(retire_valid), .retire_we(retire_we), .retire_dst(retire_dst),
        .retire_data(retire_data), .retire_pc(retire_pc),
        .flush_req(flush_req), .exc_valid(exc_valid), .exc_pc(exc_pc)
    );

    // Behavioural reference state
    int m_v[D], m_d[D], m_x[D], m_w[D], m_dst[D], m_res[D], m_pc[D];
    int m_head, m_cnt, m_trap, m_tpc;
    int m_arf[NR], m_rv[NR], m_rt[NR];

    int n_tests = 0;
    int n_fail  = 0;
    int pc_cnt  = 100;
    int seed    = 12345;
    string cur_req = "R11";

    task automatic chk(string what, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0d expected %0d", cur_req, what, act, exp);
        end
    endtask

    task automatic idle();
        disp_valid = 1'b0; disp_we = 1'b0; disp_dst = '0; disp_pc = '0;
        cmp_valid = 1'b0; cmp_tag = '0; cmp_data = '0; cmp_exc = 1'b0;
        flush_req = 1'b0;
    endtask

    task automatic model_clear();
        for (int e = 0; e < D; e++) begin m_v[e] = 0; m_d[e] = 0; m_x[e] = 0; end
        for (int r = 0; r < NR; r++) m_rv[r] = 1;
        m_cnt = 0;
    endtask

    task automatic dispatch(int dst, int we);
        disp_valid = 1'b1; disp_we = we[0]; disp_dst = AW'(dst);
        disp_pc = PW'(pc_cnt); pc_cnt++;
    endtask

    task automatic complete(int tag, int data, int exc);
        cmp_valid = 1'b1; cmp_tag = TW'(tag); cmp_data = DW'(data); cmp_exc = exc[0];
    endtask

    // Compare outputs against the model before the edge, then advance the model
    task automatic tick();
        int hd, tl, trap_now, ret, rdy, r, t;
        @(negedge clk);
        hd = m_head;
        tl = (m_head + m_cnt) % D;
        trap_now = !m_trap && m_cnt > 0 && m_d[hd] && m_x[hd];
        ret = !m_trap && m_cnt > 0 && m_d[hd] && !m_x[hd] && !flush_req;
        rdy = !m_trap && m_cnt < D && !flush_req && !trap_now;
        chk("disp_ready", disp_ready, rdy);
        chk("disp_tag", disp_tag, tl);
        chk("retire_valid", retire_valid, ret);
        if (ret) begin
            chk("retire_we", retire_we, m_w[hd]);
            chk("retire_pc", retire_pc, m_pc[hd]);
            if (m_w[hd]) begin
                chk("retire_dst", retire_dst, m_dst[hd]);
                chk("retire_data", retire_data, m_res[hd]);
            end
        end
        chk("exc_valid", exc_valid, m_trap);
        if (m_trap) chk("exc_pc", exc_pc, m_tpc);
        for (int s = 0; s < NS; s++) begin
            int er, ed;
            r = int'(src_reg[s*AW +: AW]);
            t = m_rt[r];
            er = 1; ed = 0;
            if (m_rv[r]) ed = m_arf[r];
            else if (m_d[t]) ed = m_res[t];
            else if (cmp_valid && int'(cmp_tag) == t) ed = int'(cmp_data);
            else er = 0;
            chk("src_ready", src_ready[s], er);
            if (er) chk("src_data", src_data[s*DW +: DW], ed);
            if (!m_rv[r]) chk("src_tag", src_tag[s*TW +: TW], t);
        end
        // advance reference
        if (trap_now) begin
            m_tpc = m_pc[hd]; m_trap = 1; model_clear();
        end else if (flush_req) begin
            m_trap = 0; model_clear();
        end else begin
            m_trap = 0;
            if (cmp_valid && m_v[int'(cmp_tag)]) begin
                m_d[int'(cmp_tag)] = 1; m_res[int'(cmp_tag)] = int'(cmp_data);
                m_x[int'(cmp_tag)] = int'(cmp_exc);
            end
            if (ret) begin
                if (m_w[hd]) begin
                    m_arf[m_dst[hd]] = m_res[hd];
                    if (!m_rv[m_dst[hd]] && m_rt[m_dst[hd]] == hd) m_rv[m_dst[hd]] = 1;
                end
                m_v[hd] = 0; m_d[hd] = 0;
                m_head = (hd + 1) % D; m_cnt--;
            end
            if (disp_valid && rdy) begin
                m_v[tl] = 1; m_d[tl] = 0; m_x[tl] = 0; m_w[tl] = int'(disp_we);
                m_dst[tl] = int'(disp_dst); m_pc[tl] = int'(disp_pc);
                if (disp_we) begin m_rv[int'(disp_dst)] = 0; m_rt[int'(disp_dst)] = tl; end
                m_cnt++;
            end
        end
        @(posedge clk); #1;
    endtask

    function automatic int nextr();
        seed = (seed * 1103515245 + 12345) & 32'h7fffffff;
        return seed >>> 8;
    endfunction

    initial begin
        #(8 * 100000);
        n_fail++;
        $display("FAIL watchdog: got 0 expected 1 (run did not end)");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        idle();
        src_reg = '0;
        m_head = 0; m_trap = 0; m_tpc = 0;
        for (int r = 0; r < NR; r++) begin m_arf[r] = 0; m_rt[r] = 0; end
        for (int e = 0; e < D; e++) begin m_w[e] = 0; m_dst[e] = 0; m_res[e] = 0; m_pc[e] = 0; end
        model_clear();
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R11: reset state
        cur_req = "R11";
        src_reg = {AW'(7), AW'(2)};
        tick();

        // R1 and R2: fill to capacity, fifth dispatch stalls
        cur_req = "R1";
        for (int k = 1; k <= 4; k++) begin dispatch(k, 1); tick(); end
        cur_req = "R2";
        dispatch(5, 1); tick(); tick();
        idle();

        // R3 and R6: out-of-order completions, lookups of pending writers
        cur_req = "R3";
        src_reg = {AW'(3), AW'(2)};
        complete(2, 16'h0303, 0); tick();
        cur_req = "R6";
        complete(1, 16'h0202, 0); tick();
        idle(); tick();

        // R7: completion forwarded to a same-cycle lookup
        cur_req = "R7";
        src_reg = {AW'(4), AW'(1)};
        complete(0, 16'h0101, 0); tick();
        idle();

        // R4: in-order retirement of 0,1,2 then 3
        cur_req = "R4";
        tick(); tick();
        complete(3, 16'h0404, 0); tick();
        idle(); tick(); tick();

        // R5: settled registers return file values
        cur_req = "R5";
        src_reg = {AW'(3), AW'(1)};
        tick();

        // R8: two writers to the same register
        cur_req = "R8";
        src_reg = {AW'(6), AW'(6)};
        dispatch(6, 1); tick();
        dispatch(6, 1); tick();
        idle();
        complete(disp_tag - 2'd2, 16'h0a0a, 0); tick();
        idle(); tick();
        tick();
        complete(m_rt[6], 16'h0b0b, 0); tick();
        idle(); tick(); tick();

        // R9: error at the head
        cur_req = "R9";
        src_reg = {AW'(2), AW'(1)};
        dispatch(1, 1); tick();
        dispatch(2, 1); tick();
        idle();
        complete((m_head + 1) % D, 16'h0c0c, 0); tick();
        complete(m_head, 16'h0d0d, 1); tick();
        idle(); dispatch(3, 1); tick();
        tick(); idle(); tick(); tick();

        // R10: external flush discards in-flight work
        cur_req = "R10";
        dispatch(4, 1); tick();
        dispatch(5, 1); tick();
        idle();
        complete(m_head, 16'h0e0e, 0); tick();
        idle(); flush_req = 1'b1; dispatch(7, 1); tick();
        idle(); tick();

        // R10: trap and flush in the same cycle
        dispatch(2, 1); tick();
        idle(); complete(m_head, 16'h0f0f, 1); tick();
        idle(); flush_req = 1'b1; tick();
        idle(); tick(); tick();

        // R12: completion to a slot not in flight
        cur_req = "R12";
        complete(m_head, 16'h1111, 0); tick();
        idle(); src_reg = {AW'(5), AW'(5)};
        dispatch(5, 1); tick();
        idle(); tick();

        // R4: long pseudo-random traffic with wrap-around
        cur_req = "R4";
        for (int c = 0; c < 600; c++) begin
            int sel, pick;
            idle();
            src_reg = NS*AW'(nextr());
            if (nextr() % 3 != 0) dispatch(nextr() % NR, (nextr() % 4 != 0) ? 1 : 0);
            pick = -1;
            sel = nextr() % D;
            for (int e = 0; e < D; e++) begin
                int q;
                q = (sel + e) % D;
                if (pick < 0 && m_v[q] && !m_d[q]) pick = q;
            end
            if (pick >= 0 && nextr() % 2 == 0)
                complete(pick, nextr() & 16'hffff, (nextr() % 20 == 0) ? 1 : 0);
            if (nextr() % 50 == 0) flush_req = 1'b1;
            tick();
        end
        idle();
        tick();

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule